// File: doc/BRIEF.md
# Serial NOR Flash Identity Probe

This block works out which serial NOR flash is attached to a byte-level SPI master. On a start pulse it issues the read-identity command, gathers the three answer bytes and packs them into a 24-bit device code. It then walks an internal catalogue of known parts, one row per clock. On a hit it reports the part's geometry: sector size, sector count, total capacity, and the erase command and erase unit to use. On a miss it raises an unknown flag.

An optional expected code can be supplied. When it is enabled and the probed code differs from it, the block reports a mismatch and gives no geometry. Results stay on the outputs, flagged valid, until the next start pulse.

The SPI master sees a simple request/done handshake. `xfer_req` is held with a byte on `xfer_tx` until `xfer_done` pulses for one cycle. The received byte arrives on `xfer_rx` in the same cycle as `xfer_done`. `xfer_last` marks the byte after which chip select should be released.

Top module: `nor_id_probe`

## Requirements
- R1: After reset, `res_valid`, all result flags, all geometry outputs and `xfer_req` are 0.
- R2: A probe makes exactly four transfers. The first sends 0x9F and the other three send 0x00. `xfer_last` is high only on the fourth, and only while `xfer_req` is high.
- R3: The byte received during the opcode transfer is discarded. The next three received bytes form `dev_id`: the first in bits 23:16, the second in 15:8 and the third in 7:0. `dev_id` is reported for every outcome.
- R4: The catalogue is searched in this order (code, sector bytes, sector count, small-erase flag): 0: 0x000000, 65536, 16, 0; 1: 0x1F6601, 32768, 4, 1; 2: 0x010215, 65536, 64, 0; 3: 0xBF258D, 65536, 8, 1; 4: 0x202010, 32768, 2, 0; 5: 0x202018, 262144, 64, 0; 6: 0xEF3017, 65536, 128, 1; 7: 0x208015, 65536, 32, 1. On a hit, `sect_bytes`, `sect_cnt` and `total_bytes` = sector bytes × sector count are reported, with `res_known` = 1.
- R5: A hit row with the small-erase flag gives `erase_op` = 0x20 and `erase_unit` = 4096.
- R6: A hit row without the flag gives `erase_op` = 0xD8 and `erase_unit` equal to the sector size.
- R7: A catalogue code of zero never matches. A probed code of 0x000000 gives `res_unknown` = 1.
- R8: A code found in no row gives `res_unknown` = 1 with all geometry outputs 0.
- R9: With `expect_en` = 1 and the probed code different from `expect_id`, the result is `res_mismatch` = 1 with all geometry outputs 0. With equal codes the search proceeds normally. Exactly one of `res_known`, `res_unknown` and `res_mismatch` is set while `res_valid` is high.
- R10: The search checks one row per clock, starting at row 0, and stops at the first hit. Count cycles from the cycle in which `xfer_done` is high for the last byte. `res_valid` rises 2 + k cycles later for a hit in row k, 9 cycles later for a miss, and 1 cycle later for a mismatch.
- R11: While `res_valid` is high, all result outputs stay unchanged until a start pulse. A start pulse clears `res_valid` in the next cycle.
- R12: A start pulse received while a probe is in progress is ignored. The running probe still makes exactly four transfers and reports its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_start | input | 1 | Start pulse |
| expect_en | input | 1 | Enables the expected-code comparison |
| expect_id | input | 24 | Expected device code |
| xfer_req | output | 1 | Byte transfer request to the SPI master |
| xfer_tx | output | 8 | Byte to send |
| xfer_last | output | 1 | Release chip select after this byte |
| xfer_done | input | 1 | One-cycle pulse: transfer finished |
| xfer_rx | input | 8 | Received byte, valid with `xfer_done` |
| res_valid | output | 1 | Result outputs are valid |
| res_known | output | 1 | Device found in the catalogue |
| res_unknown | output | 1 | Device not found |
| res_mismatch | output | 1 | Probed code differs from the expected code |
| dev_id | output | 24 | Probed device code |
| sect_bytes | output | 32 | Sector size in bytes |
| sect_cnt | output | 16 | Number of sectors |
| total_bytes | output | 32 | Device capacity in bytes |
| erase_op | output | 8 | Erase command byte |
| erase_unit | output | 32 | Bytes removed by one erase command |

## Verification
Two decisions can land in the same cycle.

The first case is a hit in the final catalogue row, which coincides with the end-of-table condition. It is provoked by probing 0x208015. It must come out as known, with that row's geometry and a latency of 9, not as unknown.

The second case is the capture of the last ID byte, which is also the cycle in which the expected-code comparison decides. A wrong expected code must give a mismatch one cycle after that byte's done pulse, with no search and no geometry. A matching expected code must let the search run to row 6.

A probed code of zero, which equals the empty code of row 0, checks that an empty row cannot produce a hit.

// File: rtl/nor_id_pkg.sv
package nor_id_pkg;

  localparam int unsigned ID_W    = 24;
  localparam int unsigned BYTES_W = 32;
  localparam int unsigned CNT_W   = 16;

  localparam logic [7:0] OP_READ_ID     = 8'h9F;
  localparam logic [7:0] OP_ERASE_SMALL = 8'h20;
  localparam logic [7:0] OP_ERASE_SECT  = 8'hD8;
  localparam logic [7:0] TX_FILL        = 8'h00;
  localparam logic [BYTES_W-1:0] SMALL_UNIT = 32'd4096;

  typedef struct packed {
    logic [ID_W-1:0]    id;
    logic [BYTES_W-1:0] sect_bytes;
    logic [CNT_W-1:0]   sect_cnt;
    logic               small_ok;
  } cat_row_t;

  typedef struct packed {
    logic [BYTES_W-1:0] sect_bytes;
    logic [CNT_W-1:0]   sect_cnt;
    logic [BYTES_W-1:0] total_bytes;
    logic [7:0]         erase_op;
    logic [BYTES_W-1:0] erase_unit;
  } geo_t;

  typedef enum logic [1:0] {PS_IDLE, PS_ID, PS_SCAN, PS_DONE} probe_state_t;

  localparam int unsigned CAT_ROWS = 8;

  // Catalogue of known parts; a zero code marks a row that can never hit.
  function automatic cat_row_t cat_row(input int unsigned k);
    cat_row_t r;
    r = '0;
    case (k)
      0: r = '{id: 24'h000000, sect_bytes: 32'd65536,  sect_cnt: 16'd16,  small_ok: 1'b0};
      1: r = '{id: 24'h1F6601, sect_bytes: 32'd32768,  sect_cnt: 16'd4,   small_ok: 1'b1};
      2: r = '{id: 24'h010215, sect_bytes: 32'd65536,  sect_cnt: 16'd64,  small_ok: 1'b0};
      3: r = '{id: 24'hBF258D, sect_bytes: 32'd65536,  sect_cnt: 16'd8,   small_ok: 1'b1};
      4: r = '{id: 24'h202010, sect_bytes: 32'd32768,  sect_cnt: 16'd2,   small_ok: 1'b0};
      5: r = '{id: 24'h202018, sect_bytes: 32'd262144, sect_cnt: 16'd64,  small_ok: 1'b0};
      6: r = '{id: 24'hEF3017, sect_bytes: 32'd65536,  sect_cnt: 16'd128, small_ok: 1'b1};
      7: r = '{id: 24'h208015, sect_bytes: 32'd65536,  sect_cnt: 16'd32,  small_ok: 1'b1};
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/nor_id_xfer.sv
module nor_id_xfer
  import nor_id_pkg::*;
#(
  parameter int unsigned ID_BYTES = 3,
  localparam int unsigned XFERS   = ID_BYTES + 1,
  localparam int unsigned SEQ_W   = $clog2(XFERS),
  localparam int unsigned WORD_W  = ID_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic              xfer_req,
  output logic [7:0]        xfer_tx,
  output logic              xfer_last,
  input  logic              xfer_done,
  input  logic [7:0]        xfer_rx,
  output logic              id_done,
  output logic [WORD_W-1:0] id_word
);

  localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(XFERS - 1);

  logic              busy_q, busy_d;
  logic [SEQ_W-1:0]  seq_q, seq_d;
  logic [WORD_W-1:0] shr_q, shr_d;
  logic              step;

  assign step      = busy_q && xfer_done;
  assign xfer_req  = busy_q;
  assign xfer_tx   = (seq_q == '0) ? OP_READ_ID : TX_FILL;
  assign xfer_last = busy_q && (seq_q == SEQ_LAST);
  assign id_word   = {shr_q[WORD_W-9:0], xfer_rx};
  assign id_done   = step && (seq_q == SEQ_LAST);

  always_comb begin
    busy_d = busy_q;
    seq_d  = seq_q;
    shr_d  = shr_q;
    if (go && !busy_q) begin
      busy_d = 1'b1;
      seq_d  = '0;
      shr_d  = '0;
    end else if (step) begin
      if (seq_q != '0) shr_d = id_word;
      if (seq_q == SEQ_LAST) begin
        busy_d = 1'b0;
        seq_d  = '0;
      end else begin
        seq_d = seq_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      seq_q  <= '0;
      shr_q  <= '0;
    end else begin
      busy_q <= busy_d;
      seq_q  <= seq_d;
      shr_q  <= shr_d;
    end
  end

  AST_FIRST_IS_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_req) |-> xfer_tx == OP_READ_ID) else $error("AST_FIRST_IS_OPCODE"); // R2
  AST_LAST_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_last |-> xfer_req) else $error("AST_LAST_WITH_REQ"); // R2

endmodule

// File: rtl/nor_id_catalog.sv
module nor_id_catalog
  import nor_id_pkg::*;
#(
  parameter int unsigned ROWS  = CAT_ROWS,
  parameter int unsigned IDX_W = 3
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [ID_W-1:0]  probe_id,
  output logic             hit,
  output geo_t             geo
);

  cat_row_t row;

  always_comb begin
    row = cat_row(int'(idx));
    hit = (int'(idx) < ROWS) && (row.id != '0) && (row.id == probe_id);
    geo.sect_bytes  = row.sect_bytes;
    geo.sect_cnt    = row.sect_cnt;
    geo.total_bytes = row.sect_bytes * BYTES_W'(row.sect_cnt);
    if (row.small_ok) begin
      geo.erase_op   = OP_ERASE_SMALL;
      geo.erase_unit = SMALL_UNIT;
    end else begin
      geo.erase_op   = OP_ERASE_SECT;
      geo.erase_unit = row.sect_bytes;
    end
  end

endmodule

// File: rtl/nor_id_probe.sv
module nor_id_probe
  import nor_id_pkg::*;
#(
  parameter int unsigned ROWS      = CAT_ROWS,
  localparam int unsigned IDX_W    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                probe_start,
  input  logic                expect_en,
  input  logic [ID_W-1:0]     expect_id,
  output logic                xfer_req,
  output logic [7:0]          xfer_tx,
  output logic                xfer_last,
  input  logic                xfer_done,
  input  logic [7:0]          xfer_rx,
  output logic                res_valid,
  output logic                res_known,
  output logic                res_unknown,
  output logic                res_mismatch,
  output logic [ID_W-1:0]     dev_id,
  output logic [BYTES_W-1:0]  sect_bytes,
  output logic [CNT_W-1:0]    sect_cnt,
  output logic [BYTES_W-1:0]  total_bytes,
  output logic [7:0]          erase_op,
  output logic [BYTES_W-1:0]  erase_unit
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ROWS - 1);

  probe_state_t      state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              valid_q, valid_d, known_q, known_d;
  logic              unk_q, unk_d, mis_q, mis_d;
  logic [ID_W-1:0]   id_q, id_d;
  geo_t              geo_q, geo_d, row_geo;
  logic              go, id_done, hit;
  logic [ID_W-1:0]   id_word;

  assign go = probe_start && ((state_q == PS_IDLE) || (state_q == PS_DONE));

  nor_id_xfer #(.ID_BYTES(ID_W / 8)) xfer_i (
    .clk, .rst_n, .go,
    .xfer_req, .xfer_tx, .xfer_last, .xfer_done, .xfer_rx,
    .id_done, .id_word
  );

  nor_id_catalog #(.ROWS(ROWS), .IDX_W(IDX_W)) cat_i (
    .idx(idx_q), .probe_id(id_q), .hit, .geo(row_geo)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    valid_d = valid_q;
    known_d = known_q;
    unk_d   = unk_q;
    mis_d   = mis_q;
    id_d    = id_q;
    geo_d   = geo_q;
    case (state_q)
      PS_IDLE, PS_DONE: begin
        if (go) begin
          state_d = PS_ID;
          valid_d = 1'b0;
          known_d = 1'b0;
          unk_d   = 1'b0;
          mis_d   = 1'b0;
          id_d    = '0;
          geo_d   = '0;
        end
      end
      PS_ID: begin
        if (id_done) begin
          id_d = id_word;
          if (expect_en && (id_word != expect_id)) begin
            mis_d   = 1'b1;
            valid_d = 1'b1;
            state_d = PS_DONE;
          end else begin
            idx_d   = '0;
            state_d = PS_SCAN;
          end
        end
      end
      PS_SCAN: begin
        if (hit) begin
          known_d = 1'b1;
          valid_d = 1'b1;
          geo_d   = row_geo;
          state_d = PS_DONE;
        end else if (idx_q == IDX_LAST) begin
          unk_d   = 1'b1;
          valid_d = 1'b1;
          state_d = PS_DONE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      idx_q   <= '0;
      valid_q <= 1'b0;
      known_q <= 1'b0;
      unk_q   <= 1'b0;
      mis_q   <= 1'b0;
      id_q    <= '0;
      geo_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      valid_q <= valid_d;
      known_q <= known_d;
      unk_q   <= unk_d;
      mis_q   <= mis_d;
      id_q    <= id_d;
      geo_q   <= geo_d;
    end
  end

  assign res_valid    = valid_q;
  assign res_known    = known_q;
  assign res_unknown  = unk_q;
  assign res_mismatch = mis_q;
  assign dev_id       = id_q;
  assign sect_bytes   = geo_q.sect_bytes;
  assign sect_cnt     = geo_q.sect_cnt;
  assign total_bytes  = geo_q.total_bytes;
  assign erase_op     = geo_q.erase_op;
  assign erase_unit   = geo_q.erase_unit;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $countones({res_known, res_unknown, res_mismatch}) == 1) else $error("AST_ONE_OUTCOME"); // R9
  AST_NO_EMPTY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    res_known |-> dev_id != '0) else $error("AST_NO_EMPTY_HIT"); // R7
  AST_SMALL_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_known && erase_op == OP_ERASE_SMALL) |-> erase_unit == SMALL_UNIT) else $error("AST_SMALL_UNIT"); // R5
  AST_MISMATCH_NO_GEO: assert property (@(posedge clk) disable iff (!rst_n)
    res_mismatch |-> (total_bytes == '0 && erase_op == '0 && sect_cnt == '0)) else $error("AST_MISMATCH_NO_GEO"); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !probe_start) |=> (res_valid && $stable(dev_id) && $stable(total_bytes) && $stable(erase_op))) else $error("AST_RESULT_HELD"); // R11
  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SCAN && !hit && idx_q != IDX_LAST) |=> idx_q == $past(idx_q) + 1'b1) else $error("AST_SCAN_STEP"); // R10

endmodule

// File: tb/nor_id_probe_tb_top.sv
module nor_id_probe_tb_top;
  import nor_id_pkg::*;

  logic clk, rst_n, probe_start, expect_en;
  logic [23:0] expect_id;
  logic xfer_req, xfer_last, xfer_done;
  logic [7:0] xfer_tx, xfer_rx;
  logic res_valid, res_known, res_unknown, res_mismatch;
  logic [23:0] dev_id;
  logic [31:0] sect_bytes, total_bytes, erase_unit;
  logic [15:0] sect_cnt;
  logic [7:0] erase_op;

  nor_id_probe dut_i (
    .clk, .rst_n, .probe_start, .expect_en, .expect_id,
    .xfer_req, .xfer_tx, .xfer_last, .xfer_done, .xfer_rx,
    .res_valid, .res_known, .res_unknown, .res_mismatch, .dev_id,
    .sect_bytes, .sect_cnt, .total_bytes, .erase_op, .erase_unit
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [23:0] id;
    logic        known, unknown, mismatch;
    logic [31:0] sb;
    logic [15:0] sc;
    logic [31:0] tot;
    logic [7:0]  op;
    logic [31:0] unit;
    int          lat;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  int cyc = 0, last_done_cyc = 0, xcnt = 0, seen = 0;
  logic [7:0] resp [4];
  logic [7:0] tx_log [8];
  logic       last_log [8];
  logic prev_valid = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // SPI master model: answers each request after a short delay
  initial begin
    xfer_done = 1'b0;
    xfer_rx   = 8'h00;
    forever begin
      @(negedge clk);
      if (xfer_req && rst_n) begin
        repeat (2) @(negedge clk);
        if (xcnt < 8) begin
          tx_log[xcnt]   = xfer_tx;
          last_log[xcnt] = xfer_last;
        end
        xfer_rx = (xcnt < 4) ? resp[xcnt] : 8'hEE;
        if (xcnt == 3) last_done_cyc = cyc;
        xcnt++;
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
      end
    end
  end

  // Monitor: pops the expected result on each new valid result
  initial begin
    forever begin
      @(negedge clk);
      if (res_valid && !prev_valid) begin
        exp_t e;
        seen++;
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R11 unexpected result: actual valid 1 expected 0");
        end else begin
          e = exp_q.pop_front();
          chk("R2", "transfer count", xcnt, 4);
          chk("R2", "opcode byte", {24'h0, tx_log[0]}, 32'h9F);
          for (int i = 1; i < 4; i++) chk("R2", "fill byte", {24'h0, tx_log[i]}, 32'h0);
          chk("R2", "last flags", {28'h0, last_log[3], last_log[2], last_log[1], last_log[0]}, 32'h8);
          chk("R3", "dev_id", {8'h0, dev_id}, {8'h0, e.id});
          chk("R9", "outcome flags", {29'h0, res_known, res_unknown, res_mismatch},
              {29'h0, e.known, e.unknown, e.mismatch});
          chk("R4", "sect_bytes", sect_bytes, e.sb);
          chk("R4", "sect_cnt", {16'h0, sect_cnt}, {16'h0, e.sc});
          chk("R4", "total_bytes", total_bytes, e.tot);
          chk("R5_R6", "erase_op", {24'h0, erase_op}, {24'h0, e.op});
          chk("R5_R6", "erase_unit", erase_unit, e.unit);
          chk("R10", "latency", cyc - last_done_cyc, e.lat);
        end
      end
      prev_valid = res_valid;
    end
  end

  function automatic exp_t mk(input logic [23:0] id, input logic k, input logic u, input logic m,
                              input logic [31:0] sb, input logic [15:0] sc, input logic sm, input int lat);
    exp_t e;
    e.id = id; e.known = k; e.unknown = u; e.mismatch = m;
    e.sb = sb; e.sc = sc; e.tot = sb * {16'h0, sc};
    e.op = !k ? 8'h00 : (sm ? 8'h20 : 8'hD8);
    e.unit = !k ? 32'h0 : (sm ? 32'd4096 : sb);
    e.lat = lat;
    return e;
  endfunction

  task automatic run_probe(input logic [23:0] id, input logic en, input logic [23:0] eid,
                           input exp_t e, input bit poke);
    @(negedge clk);
    xcnt = 0;
    resp[0] = 8'hA5; resp[1] = id[23:16]; resp[2] = id[15:8]; resp[3] = id[7:0];
    expect_en = en; expect_id = eid;
    exp_q.push_back(e);
    probe_start = 1'b1;
    @(negedge clk);
    probe_start = 1'b0;
    chk("R11", "valid cleared by start", {31'h0, res_valid}, 32'h0);
    if (poke) begin
      repeat (3) @(negedge clk);
      probe_start = 1'b1;   // R12: ignored while busy
      @(negedge clk);
      probe_start = 1'b0;
    end
    while (!res_valid) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; probe_start = 1'b0; expect_en = 1'b0; expect_id = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "res_valid", {31'h0, res_valid}, 32'h0);
    chk("R1", "xfer_req", {31'h0, xfer_req}, 32'h0);
    chk("R1", "flags", {29'h0, res_known, res_unknown, res_mismatch}, 32'h0);
    chk("R1", "total_bytes", total_bytes, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "idle xfer_req", {31'h0, xfer_req}, 32'h0);

    // R4 R5: row 1, small erase
    run_probe(24'h1F6601, 1'b0, 24'h0, mk(24'h1F6601, 1, 0, 0, 32'd32768, 16'd4, 1, 3), 0);
    // R11: result held
    begin
      logic [23:0] id_s; logic [31:0] tot_s;
      id_s = dev_id; tot_s = total_bytes;
      repeat (20) @(negedge clk);
      chk("R11", "valid held", {31'h0, res_valid}, 32'h1);
      chk("R11", "dev_id held", {8'h0, dev_id}, {8'h0, id_s});
      chk("R11", "total held", total_bytes, tot_s);
    end
    // R6: row 5, sector erase
    run_probe(24'h202018, 1'b0, 24'h0, mk(24'h202018, 1, 0, 0, 32'd262144, 16'd64, 0, 7), 0);
    // R10: last row hit coincides with end of table
    run_probe(24'h208015, 1'b0, 24'h0, mk(24'h208015, 1, 0, 0, 32'd65536, 16'd32, 1, 9), 0);
    // R7: zero code never matches
    run_probe(24'h000000, 1'b0, 24'h0, mk(24'h000000, 0, 1, 0, 32'h0, 16'h0, 0, 9), 0);
    // R8: unlisted code
    run_probe(24'h123456, 1'b0, 24'h0, mk(24'h123456, 0, 1, 0, 32'h0, 16'h0, 0, 9), 0);
    // R9: expected code differs
    run_probe(24'hEF3017, 1'b1, 24'hEF3016, mk(24'hEF3017, 0, 0, 1, 32'h0, 16'h0, 0, 1), 0);
    // R9: expected code equal, search proceeds
    run_probe(24'hEF3017, 1'b1, 24'hEF3017, mk(24'hEF3017, 1, 0, 0, 32'd65536, 16'd128, 1, 8), 0);
    // R12: start while busy ignored
    run_probe(24'h010215, 1'b0, 24'h0, mk(24'h010215, 1, 0, 0, 32'd65536, 16'd64, 0, 4), 1);
    repeat (10) @(negedge clk);
    chk("R12", "results seen", seen, 8);
    chk("R12", "queue drained", exp_q.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule